// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory with Fault Injection

This block is a synchronous memory of 512 words. Each word holds 64 data bits and 8 check bits from an extended Hamming code. A write stores the data together with check bits computed from it. Two inject inputs can invert fixed data bits in the stored copy, so that software and test benches can exercise the error paths on purpose. A read returns the data one clock later. A single-bit error is corrected. Single-bit and double-bit errors each raise a flag. The address of the word being presented comes out in the same cycle as the data.

The check bits that the encoder computes from the current write data also appear on a separate output, so the encoder can be used on its own. When several of these memories are built into one wider or deeper store, each memory ORs its own error flags with the flags it receives from the previous memory in the chain. It then passes the result on to the next memory, so the last memory in the chain reports an error seen in any of them.

The code places 71 bits at positions 1 to 71. Hamming check bit k sits at position 2^k, for k from 0 to 6. Data bits fill the remaining positions in ascending order, with data bit 0 at the lowest free position. Check bit k is the XOR of every data bit whose position has bit k set. Check bit 7 is the even parity over all 64 data bits and check bits 0 to 6.

Top module: `secded_ram`

## Requirements
- R1: When `rdEn` is high at a clock edge, `rdData` presents the word stored at `rdAddr` right after that same edge. A word written without injection reads back unchanged, with `errSingle` and `errDouble` both low.
- R2: `encCheck` is combinational in `wrData`. Bits 0 to 6 follow the Hamming rule given above, and bit 7 is the even overall parity.
- R3: A write with only `injSingle` high stores the word with data bit 30 inverted. A later read of that address returns the original data, with `errSingle` high and `errDouble` low.
- R4: A write with `injDouble` high stores the word with data bits 30 and 62 inverted. A later read raises `errDouble`, keeps `errSingle` low, and returns the stored data uncorrected, with both bits still inverted.
- R5: When `injSingle` and `injDouble` are high on the same write, a double-bit error is stored, exactly as in R4.
- R6: `rdAddrOut` changes on the same edge as `rdData` and holds the address of the word being presented.
- R7: `cascSingleOut` is the OR of the local single-error result and `cascSingleIn`. `cascDoubleOut` is the OR of the local double-error result and `cascDoubleIn`. Both are sampled on the read edge and update together with `rdData`.
- R8: The cascade inputs have no effect on `rdData`, `rdAddrOut`, `errSingle`, `errDouble` or `encCheck`.
- R9: A synchronous reset (`rst` high) clears `rdData`, `rdAddrOut`, both local error flags and both cascade outputs. It leaves the memory contents intact.
- R10: While `rdEn` is low, every read-side output holds its value, even when `rdAddr` or the cascade inputs change.
- R11: A clean write to an address that holds an injected error replaces the whole word, and a later read of that address reports no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 9 | Write address |
| wrData | input | 64 | Write data |
| injSingle | input | 1 | Invert data bit 30 in the stored word on this write |
| injDouble | input | 1 | Invert data bits 30 and 62 in the stored word on this write |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 9 | Read address |
| cascSingleIn | input | 1 | Single-error status from the previous memory in the chain |
| cascDoubleIn | input | 1 | Double-error status from the previous memory in the chain |
| rdData | output | 64 | Read data, corrected when a single error is found |
| rdAddrOut | output | 9 | Address of the word on rdData |
| errSingle | output | 1 | Local correctable-error flag |
| errDouble | output | 1 | Local uncorrectable-error flag |
| cascSingleOut | output | 1 | Local single flag ORed with cascSingleIn |
| cascDoubleOut | output | 1 | Local double flag ORed with cascDoubleIn |
| encCheck | output | 8 | Check bits of wrData, for encode-only use |

## Verification
The bench writes words with both inject inputs high. A design that gave the single inject priority would report a correctable error where R5 expects `errDouble`. A double-error read must return the data uncorrected. A decoder that tried to "correct" it would flip a third bit, and the bench compares every data bit against the raw stored value. The bench drives the cascade inputs high during clean reads and during idle cycles. A chain that is combinational or left unregistered, or that leaks into the local flags, shows up as an early or wrong change on the cascade or local outputs. The bench also reads after a reset. A design whose reset cleared the memory array would lose words written earlier.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W   = 64;
  localparam int HAM_W    = 7;
  localparam int CHK_W    = HAM_W + 1;
  localparam int WORD_W   = DATA_W + CHK_W;
  localparam int LAST_POS = DATA_W + HAM_W;
  localparam int INJ_LO   = 30;
  localparam int INJ_HI   = 62;

  typedef struct packed {
    logic store;
    logic flipLo;
    logic flipHi;
    logic capture;
    logic clear;
  } eccStrobes_t;

  // Codeword position of data bit idx: the idx-th position in 1..LAST_POS
  // that is not a power of two.
  function automatic logic [HAM_W-1:0] dataPos(input int idx);
    int cnt;
    logic [HAM_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 1; p <= LAST_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p[HAM_W-1:0];
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] ham;
    ham = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) ham = ham ^ dataPos(i);
    end
    return {(^d) ^ (^ham), ham};
  endfunction
endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic        rst,
  input  logic        wrEn,
  input  logic        injSingle,
  input  logic        injDouble,
  input  logic        rdEn,
  output eccStrobes_t strobes
);
  always_comb begin
    strobes.store   = wrEn;
    // Double injection wins: both bits flip whenever injDouble is high.
    strobes.flipLo  = wrEn & (injSingle | injDouble);
    strobes.flipHi  = wrEn & injDouble;
    strobes.clear   = rst;
    strobes.capture = rdEn & ~rst;
  end
endmodule

// File: rtl/secded_dp.sv
module secded_dp
  import secded_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  eccStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              cascSingleIn,
  input  logic              cascDoubleIn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddrOut,
  output logic              errSingle,
  output logic              errDouble,
  output logic              cascSingleOut,
  output logic              cascDoubleOut,
  output logic [CHK_W-1:0]  encCheck
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] flipMask;
  logic [WORD_W-1:0] rawWord;
  logic [DATA_W-1:0] rawData;
  logic [CHK_W-1:0]  rawChk;
  logic [HAM_W-1:0]  syndrome;
  logic              parityOdd;
  logic              locSingle;
  logic              locDouble;
  logic [DATA_W-1:0] fixedData;

  assign encCheck = encode(wrData);

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      if (b == INJ_LO) begin : g_lo
        assign flipMask[b] = strobes.flipLo;
      end else if (b == INJ_HI) begin : g_hi
        assign flipMask[b] = strobes.flipHi;
      end else begin : g_none
        assign flipMask[b] = 1'b0;
      end
    end
  endgenerate

  // Check bits come from the clean data, so any flip shows as a syndrome.
  always_ff @(posedge clk) begin
    if (strobes.store) mem[wrAddr] <= {encCheck, wrData ^ flipMask};
  end

  assign rawWord = mem[rdAddr];
  assign rawData = rawWord[DATA_W-1:0];
  assign rawChk  = rawWord[WORD_W-1:DATA_W];

  always_comb begin
    syndrome = rawChk[HAM_W-1:0];
    for (int i = 0; i < DATA_W; i++) begin
      if (rawData[i]) syndrome = syndrome ^ dataPos(i);
    end
    parityOdd = (^rawData) ^ (^rawChk);
    locSingle = parityOdd;
    locDouble = ~parityOdd & (syndrome != '0);
    fixedData = rawData;
    if (locSingle) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (dataPos(i) == syndrome) fixedData[i] = ~rawData[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      rdData        <= '0;
      rdAddrOut     <= '0;
      errSingle     <= 1'b0;
      errDouble     <= 1'b0;
      cascSingleOut <= 1'b0;
      cascDoubleOut <= 1'b0;
    end else if (strobes.capture) begin
      rdData        <= fixedData;
      rdAddrOut     <= rdAddr;
      errSingle     <= locSingle;
      errDouble     <= locDouble;
      cascSingleOut <= locSingle | cascSingleIn;
      cascDoubleOut <= locDouble | cascDoubleIn;
    end
  end
endmodule

// File: rtl/secded_ram.sv
module secded_ram
  import secded_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [63:0]       wrData,
  input  logic              injSingle,
  input  logic              injDouble,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              cascSingleIn,
  input  logic              cascDoubleIn,
  output logic [63:0]       rdData,
  output logic [ADDR_W-1:0] rdAddrOut,
  output logic              errSingle,
  output logic              errDouble,
  output logic              cascSingleOut,
  output logic              cascDoubleOut,
  output logic [7:0]        encCheck
);
  eccStrobes_t strobes;

  secded_ctrl i_ctrl (
    .rst       (rst),
    .wrEn      (wrEn),
    .injSingle (injSingle),
    .injDouble (injDouble),
    .rdEn      (rdEn),
    .strobes   (strobes)
  );

  secded_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk           (clk),
    .strobes       (strobes),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .rdAddr        (rdAddr),
    .cascSingleIn  (cascSingleIn),
    .cascDoubleIn  (cascDoubleIn),
    .rdData        (rdData),
    .rdAddrOut     (rdAddrOut),
    .errSingle     (errSingle),
    .errDouble     (errDouble),
    .cascSingleOut (cascSingleOut),
    .cascDoubleOut (cascDoubleOut),
    .encCheck      (encCheck)
  );
endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              cascSingleIn,
  input logic              cascDoubleIn,
  input logic [63:0]       rdData,
  input logic [ADDR_W-1:0] rdAddrOut,
  input logic              errSingle,
  input logic              errDouble,
  input logic              cascSingleOut,
  input logic              cascDoubleOut
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(errSingle && errDouble)); // R4
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst) rdEn |=> rdAddrOut == $past(rdAddr)); // R6
  AST_CASC_SINGLE: assert property (@(posedge clk) disable iff (rst) rdEn |=> cascSingleOut == (errSingle || $past(cascSingleIn))); // R7
  AST_CASC_DOUBLE: assert property (@(posedge clk) disable iff (rst) rdEn |=> cascDoubleOut == (errDouble || $past(cascDoubleIn))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !rdEn |=> $stable(rdData) && $stable(rdAddrOut) && $stable(errSingle) && $stable(errDouble) && $stable(cascSingleOut) && $stable(cascDoubleOut)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> rdData == '0 && rdAddrOut == '0 && !errSingle && !errDouble && !cascSingleOut && !cascDoubleOut); // R9
endmodule

bind secded_ram secded_ram_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_secded_ram.sv
module test_secded_ram;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst, wrEn, injSingle, injDouble, rdEn, cascSingleIn, cascDoubleIn;
  logic [8:0]  wrAddr, rdAddr, rdAddrOut;
  logic [63:0] wrData, rdData;
  logic        errSingle, errDouble, cascSingleOut, cascDoubleOut;
  logic [7:0]  encCheck;
  int          total = 0;
  int          failCnt = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  secded_ram i_secded_ram (.*);

  function automatic logic [7:0] benchEnc(input logic [63:0] d);
    logic [6:0] h = '0;
    int k = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) h = h ^ p[6:0];
        k++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [8:0] a, input logic [63:0] d, input logic s, input logic db);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d; injSingle = s; injDouble = db;
    @(negedge clk);
    wrEn = 0; injSingle = 0; injDouble = 0;
  endtask

  task automatic doRead(input logic [8:0] a, input logic cs, input logic cd);
    @(negedge clk);
    rdEn = 1; rdAddr = a; cascSingleIn = cs; cascDoubleIn = cd;
    @(negedge clk);
    rdEn = 0; cascSingleIn = 0; cascDoubleIn = 0;
  endtask

  task automatic expectRead(input string tag, input logic [63:0] d, input logic [8:0] a,
                            input logic s, input logic db);
    chk({tag, " data"}, rdData, d);
    chk({tag, " addr R6"}, 64'(rdAddrOut), 64'(a));
    chk({tag, " single"}, 64'(errSingle), 64'(s));
    chk({tag, " double"}, 64'(errDouble), 64'(db));
  endtask

  task automatic testReset();
    chk("R9 reset rdData", rdData, '0);
    chk("R9 reset flags", 64'({errSingle, errDouble, cascSingleOut, cascDoubleOut}), 64'(0));
    chk("R9 reset addr", 64'(rdAddrOut), 64'(0));
  endtask

  task automatic testEncode();
    logic [63:0] pats [5] = '{64'h0, '1, 64'h1, 64'hAAAA_5555_F0F0_0F0F, 64'h8000_0000_0000_0000};
    foreach (pats[i]) begin
      @(negedge clk);
      wrData = pats[i];
      #1;
      chk("R2 encCheck", 64'(encCheck), 64'(benchEnc(pats[i])));
    end
  endtask

  task automatic testClean();
    doWrite(9'd0, 64'h0123_4567_89AB_CDEF, 0, 0);
    doWrite(9'd511, 64'hFFFF_0000_FFFF_0000, 0, 0);
    doWrite(9'd100, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
    doRead(9'd0, 0, 0);   expectRead("R1 addr0", 64'h0123_4567_89AB_CDEF, 9'd0, 0, 0);
    doRead(9'd511, 0, 0); expectRead("R1 addr511", 64'hFFFF_0000_FFFF_0000, 9'd511, 0, 0);
    doRead(9'd100, 0, 0); expectRead("R1 addr100", 64'hDEAD_BEEF_CAFE_F00D, 9'd100, 0, 0);
  endtask

  task automatic testInject();
    logic [63:0] d = 64'h5A5A_5A5A_5A5A_5A5A;
    logic [63:0] both = d ^ (64'h1 << 30) ^ (64'h1 << 62);
    doWrite(9'd5, d, 1, 0);
    doRead(9'd5, 0, 0); expectRead("R3 single inject", d, 9'd5, 1, 0);
    doWrite(9'd6, d, 0, 1);
    doRead(9'd6, 0, 0); expectRead("R4 double inject", both, 9'd6, 0, 1);
    doWrite(9'd7, d, 1, 1);
    doRead(9'd7, 0, 0); expectRead("R5 both inject", both, 9'd7, 0, 1);
    doWrite(9'd5, 64'h1111_2222_3333_4444, 0, 0);
    doRead(9'd5, 0, 0); expectRead("R11 overwrite", 64'h1111_2222_3333_4444, 9'd5, 0, 0);
  endtask

  task automatic testCascade();
    doRead(9'd100, 1, 1);
    expectRead("R8 clean with casc in", 64'hDEAD_BEEF_CAFE_F00D, 9'd100, 0, 0);
    chk("R7 casc pass-through", 64'({cascSingleOut, cascDoubleOut}), 64'(2'b11));
    doRead(9'd7, 0, 0);
    chk("R7 local double out", 64'({cascSingleOut, cascDoubleOut}), 64'(2'b01));
    doWrite(9'd8, 64'h0F, 1, 0);
    doRead(9'd8, 0, 1);
    chk("R7 mixed", 64'({cascSingleOut, cascDoubleOut, errSingle, errDouble}), 64'(4'b1110));
    @(negedge clk);
    wrData = 64'h1234; cascSingleIn = 1; cascDoubleIn = 1;
    #1;
    chk("R8 encCheck vs casc", 64'(encCheck), 64'(benchEnc(64'h1234)));
    cascSingleIn = 0; cascDoubleIn = 0;
  endtask

  task automatic testHold();
    doRead(9'd0, 0, 0);
    @(negedge clk);
    rdAddr = 9'd7; cascSingleIn = 1; cascDoubleIn = 1;
    repeat (2) @(negedge clk);
    expectRead("R10 hold", 64'h0123_4567_89AB_CDEF, 9'd0, 0, 0);
    chk("R10 hold casc", 64'({cascSingleOut, cascDoubleOut}), 64'(0));
    cascSingleIn = 0; cascDoubleIn = 0;
  endtask

  task automatic testResetKeepsMem();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    testReset();
    doRead(9'd511, 0, 0);
    expectRead("R9 memory kept", 64'hFFFF_0000_FFFF_0000, 9'd511, 0, 0);
  endtask

  initial begin
    rst = 1; wrEn = 0; injSingle = 0; injDouble = 0; rdEn = 0;
    cascSingleIn = 0; cascDoubleIn = 0; wrAddr = '0; rdAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testEncode();
    testClean();
    testInject();
    testCascade();
    testHold();
    testResetKeepsMem();
    done = 1;
    $display("%0d/%0d checks passed", total - failCnt, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failCnt, total);
      $finish;
    end
  end
endmodule